// File: doc/BRIEF.md
# Time-Slot Serial Receiver With Alternating Byte Pools

This block takes a serial bit stream that is valid only inside a selected time-slot and packs the bits into bytes. The slot window is marked by an enable line. A byte always starts on the first bit of the slot, so byte boundaries in storage follow byte boundaries in the slot. Bytes go into one of two 32-byte pools. The receive side fills one pool while software reads the other through an index-addressed read port.

When the filling pool holds 32 bytes it is handed to software, and the pool-full status rises. Software releases a pool with an acknowledge command. If the filling pool completes while software still holds the other pool, the receiver stops storing and sets a sticky overflow status for every byte it has to drop. A reset command returns the receiver to idle and empties both pools. A start command arms it.

Top module: `tslot_rx_pingpong`

## Requirements
- R1: After `rst_n` is low at a clock edge, `rx_active`, `pool_full` and `overflow` are 0 and `rd_data` reads 0.
- R2: `cmd_start` sets `rx_active`. While `rx_active` is 0, serial bits are not stored.
- R3: A bit is sampled at a rising clock edge only while `slot_en` is high and the receiver is active. Capture begins only at a slot start (a rise of `slot_en`) seen while active, so a slot already in progress at activation is ignored. Bits are packed MSB first: the first bit of a slot becomes bit 7 of byte 0.
- R4: Bits left over when a slot ends with fewer than 8 new bits are discarded. The next slot starts a fresh byte.
- R5: When 32 bytes have been stored in the filling pool and the other pool is free, the pools swap and `pool_full` becomes 1. `rd_data` then returns, combinationally, the byte stored in order `rd_idx` (0 to 31) of that pool.
- R6: While `pool_full` is 1 and the filling pool already holds 32 bytes, each further byte is dropped and `overflow` is set. `overflow` stays set until a reset command. The pool being read is not changed.
- R7: `cmd_ack` while `pool_full` is 1 releases the pool being read. If the filling pool is complete, the pools swap at once and `pool_full` stays 1 with the new contents. Otherwise `pool_full` clears and `rd_data` reads 0.
- R8: `cmd_ack` while `pool_full` is 0 has no effect on status or on stored bytes.
- R9: If `cmd_ack` arrives in the same cycle as the byte that completes the filling pool, the pools swap, `pool_full` stays 1 and the new bytes are readable.
- R10: `cmd_reset` clears `rx_active`, `pool_full` and `overflow`, discards any partial byte and empties both pools. It takes priority over `cmd_start` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock; all sampling on rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| ser_in | input | 1 | Serial data, MSB first |
| slot_en | input | 1 | High during the selected time-slot |
| cmd_start | input | 1 | Arm the receiver (one-cycle pulse) |
| cmd_ack | input | 1 | Release the pool being read |
| cmd_reset | input | 1 | Return to idle and empty both pools |
| rd_idx | input | 5 | Byte index into the readable pool |
| rd_data | output | 8 | Byte at `rd_idx`, 0 when no pool is held |
| rx_active | output | 1 | Receiver armed |
| pool_full | output | 1 | A full pool is held for software |
| overflow | output | 1 | Sticky: a byte was dropped |

## Verification
An acknowledge and the completion of the filling pool can fall in the same cycle. The acknowledge frees the held pool, and the completing byte makes the filling pool ready to swap. The bench provokes this by pulsing `cmd_ack` in the cycle right after the last bit of the 32nd byte, which is the cycle in which that byte is committed. It then requires that `pool_full` never drops and that all 32 indices return the new pattern, not the previously held bytes. A second collision, reset and start in one cycle, is judged by `rx_active` staying 0.

// File: rtl/tsrx_pkg.sv
// Shared sizing constants for the time-slot receiver.
// Assumes the pool depth is a power of two.
package tsrx_pkg;
    parameter int TSRX_BYTE_W = 8;
    parameter int TSRX_DEPTH  = 32;
endpackage

// File: rtl/tsrx_deser.sv
// Slot-aligned deserializer: samples ser_in while the slot is open and the
// receiver is armed, restarting byte assembly at every slot start.
// Assumes slot_en is synchronous to clk. Emits a one-cycle byte strobe.
module tsrx_deser #(
    parameter int BYTE_W = tsrx_pkg::TSRX_BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              srst,
    input  logic              rx_active,
    input  logic              slot_en,
    input  logic              ser_in,
    output logic              byte_vld,
    output logic [BYTE_W-1:0] byte_data
);
    localparam int CNT_W = $clog2(BYTE_W);

    logic              slot_q;
    logic              cap_q;
    logic [CNT_W-1:0]  bit_cnt;
    logic [BYTE_W-1:0] shreg;
    logic              slot_start;
    logic              take;
    logic [CNT_W-1:0]  cnt_cur;
    logic [BYTE_W-1:0] sh_next;

    // Decode slot start and whether this bit is captured.
    always_comb begin
        slot_start = slot_en & ~slot_q;
        take       = slot_en & rx_active & (slot_start | cap_q);
        cnt_cur    = slot_start ? '0 : bit_cnt;
        sh_next    = {shreg[BYTE_W-2:0], ser_in};
    end

    // Track slot edges and whether capture is enabled for this slot.
    always_ff @(posedge clk) begin
        if (!rst_n || srst) begin
            slot_q <= 1'b0;
            cap_q  <= 1'b0;
        end else begin
            slot_q <= slot_en;
            if (!slot_en || !rx_active) cap_q <= 1'b0;
            else if (slot_start)        cap_q <= 1'b1;
        end
    end

    // Shift bits MSB first and emit a byte every BYTE_W captured bits.
    always_ff @(posedge clk) begin
        if (!rst_n || srst) begin
            bit_cnt   <= '0;
            shreg     <= '0;
            byte_vld  <= 1'b0;
            byte_data <= '0;
        end else begin
            byte_vld <= 1'b0;
            if (take) begin
                shreg <= sh_next;
                if (cnt_cur == CNT_W'(BYTE_W - 1)) begin
                    bit_cnt   <= '0;
                    byte_vld  <= 1'b1;
                    byte_data <= sh_next;
                end else begin
                    bit_cnt <= cnt_cur + 1'b1;
                end
            end
        end
    end

    AST_BYTE_IN_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
        byte_vld |-> $past(slot_en && rx_active)); // R3
    AST_SLOT_REALIGN: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_start && rx_active && !srst) |=> (bit_cnt == CNT_W'(1))); // R4
endmodule

// File: rtl/tsrx_pool_ctrl.sv
// Pool controller: owns the armed flag, the fill pointer, the swap decision
// and the status bits. Assumes one byte strobe per cycle at most.
module tsrx_pool_ctrl #(
    parameter int DEPTH = tsrx_pkg::TSRX_DEPTH
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     srst,
    input  logic                     start,
    input  logic                     ack,
    input  logic                     byte_vld,
    output logic                     rx_active,
    output logic                     pool_full,
    output logic                     overflow,
    output logic                     fill_sel,
    output logic                     wr_en,
    output logic [$clog2(DEPTH)-1:0] wr_idx
);
    localparam int IDX_W = $clog2(DEPTH);

    logic [IDX_W-1:0] fill_cnt;
    logic             fill_full;
    logic             last_wr;
    logic             full_now;
    logic             ack_eff;
    logic             swap;

    // Decide write, completion and swap for this cycle.
    always_comb begin
        wr_en    = byte_vld & ~fill_full;
        wr_idx   = fill_cnt;
        last_wr  = wr_en & (fill_cnt == IDX_W'(DEPTH - 1));
        full_now = fill_full | last_wr;
        ack_eff  = ack & pool_full;
        swap     = full_now & (~pool_full | ack_eff);
    end

    // Update armed flag, fill pointer, pool ownership and status.
    always_ff @(posedge clk) begin
        if (!rst_n || srst) begin
            rx_active <= 1'b0;
            pool_full <= 1'b0;
            overflow  <= 1'b0;
            fill_sel  <= 1'b0;
            fill_cnt  <= '0;
            fill_full <= 1'b0;
        end else begin
            if (start) rx_active <= 1'b1;
            if (byte_vld && fill_full) overflow <= 1'b1;
            if (swap) begin
                fill_sel  <= ~fill_sel;
                fill_cnt  <= '0;
                fill_full <= 1'b0;
                pool_full <= 1'b1;
            end else begin
                if (wr_en)   fill_cnt  <= fill_cnt + 1'b1;
                if (last_wr) fill_full <= 1'b1;
                if (ack_eff) pool_full <= 1'b0;
            end
        end
    end

    AST_FULL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (pool_full && !ack && !srst) |=> pool_full); // R5
    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (overflow && !srst) |=> overflow); // R6
    AST_OVF_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(overflow) |-> $past(byte_vld && fill_full)); // R6
    AST_SWAP_HANDS_OVER: assert property (@(posedge clk) disable iff (!rst_n)
        ((fill_sel != $past(fill_sel)) && !$past(srst)) |-> pool_full); // R7
    AST_IDLE_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        (!pool_full && !fill_full && !byte_vld && !srst) |=> (!pool_full && !overflow == !$past(overflow))); // R8
    AST_RESET_CMD: assert property (@(posedge clk) disable iff (!rst_n)
        srst |=> (!rx_active && !pool_full && !overflow)); // R10
endmodule

// File: rtl/tsrx_pool_mem.sv
// Two byte pools. Writes go to the pool chosen by the controller; reads
// come combinationally from the other pool. No reset on storage.
module tsrx_pool_mem #(
    parameter int BYTE_W = tsrx_pkg::TSRX_BYTE_W,
    parameter int DEPTH  = tsrx_pkg::TSRX_DEPTH
) (
    input  logic                     clk,
    input  logic                     wr_en,
    input  logic                     wr_half,
    input  logic [$clog2(DEPTH)-1:0] wr_idx,
    input  logic [BYTE_W-1:0]        wr_data,
    input  logic                     rd_half,
    input  logic [$clog2(DEPTH)-1:0] rd_idx,
    output logic [BYTE_W-1:0]        rd_data
);
    localparam int HALVES = 2;

    logic [BYTE_W-1:0] pool_rd [HALVES];

    for (genvar h = 0; h < HALVES; h++) begin : g_half
        logic [BYTE_W-1:0] mem [DEPTH];

        // Store a byte into this pool when it is the write target.
        always_ff @(posedge clk) begin
            if (wr_en && (wr_half == 1'(h))) mem[wr_idx] <= wr_data;
        end

        assign pool_rd[h] = mem[rd_idx];
    end

    // Select the pool that software owns.
    always_comb rd_data = pool_rd[rd_half];
endmodule

// File: rtl/tslot_rx_pingpong.sv
// Top of the time-slot receiver: deserializer, pool controller and the
// two-pool store. Assumes every input is synchronous to clk.
module tslot_rx_pingpong #(
    parameter int BYTE_W = tsrx_pkg::TSRX_BYTE_W,
    parameter int DEPTH  = tsrx_pkg::TSRX_DEPTH
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     ser_in,
    input  logic                     slot_en,
    input  logic                     cmd_start,
    input  logic                     cmd_ack,
    input  logic                     cmd_reset,
    input  logic [$clog2(DEPTH)-1:0] rd_idx,
    output logic [BYTE_W-1:0]        rd_data,
    output logic                     rx_active,
    output logic                     pool_full,
    output logic                     overflow
);
    localparam int IDX_W = $clog2(DEPTH);

    logic              byte_vld;
    logic [BYTE_W-1:0] byte_data;
    logic              fill_sel;
    logic              wr_en;
    logic [IDX_W-1:0]  wr_idx;
    logic [BYTE_W-1:0] mem_rd;

    tsrx_deser #(.BYTE_W(BYTE_W)) u_deser (
        .clk(clk), .rst_n(rst_n), .srst(cmd_reset), .rx_active(rx_active),
        .slot_en(slot_en), .ser_in(ser_in),
        .byte_vld(byte_vld), .byte_data(byte_data)
    );

    tsrx_pool_ctrl #(.DEPTH(DEPTH)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .srst(cmd_reset), .start(cmd_start),
        .ack(cmd_ack), .byte_vld(byte_vld), .rx_active(rx_active),
        .pool_full(pool_full), .overflow(overflow), .fill_sel(fill_sel),
        .wr_en(wr_en), .wr_idx(wr_idx)
    );

    tsrx_pool_mem #(.BYTE_W(BYTE_W), .DEPTH(DEPTH)) u_mem (
        .clk(clk), .wr_en(wr_en), .wr_half(fill_sel), .wr_idx(wr_idx),
        .wr_data(byte_data), .rd_half(~fill_sel), .rd_idx(rd_idx),
        .rd_data(mem_rd)
    );

    // Present stored bytes only while a pool is held for software.
    always_comb rd_data = pool_full ? mem_rd : '0;

    AST_RESET_IDLE: assert property (@(posedge clk)
        $past(!rst_n) |-> (!rx_active && !pool_full && !overflow)); // R1
    AST_NO_READ_WHEN_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        !pool_full |-> (rd_data == '0)); // R7
endmodule

// File: tb/tslot_rx_pingpong_tb.sv
module tslot_rx_pingpong_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ser_in = 1'b0;
    logic       slot_en = 1'b0;
    logic       cmd_start = 1'b0;
    logic       cmd_ack = 1'b0;
    logic       cmd_reset = 1'b0;
    logic [4:0] rd_idx = '0;
    logic [7:0] rd_data;
    logic       rx_active, pool_full, overflow;

    int n_chk = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    tslot_rx_pingpong u_dut (
        .clk(clk), .rst_n(rst_n), .ser_in(ser_in), .slot_en(slot_en),
        .cmd_start(cmd_start), .cmd_ack(cmd_ack), .cmd_reset(cmd_reset),
        .rd_idx(rd_idx), .rd_data(rd_data), .rx_active(rx_active),
        .pool_full(pool_full), .overflow(overflow)
    );

    function automatic logic [7:0] pat(int set, int i);
        return 8'(((i * 29 + set * 71 + 3) ^ (set * 17 + 5)) & 255);
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic pulse(ref logic sig);
        @(negedge clk) sig = 1'b1;
        @(negedge clk) sig = 1'b0;
    endtask

    task automatic send_byte(logic [7:0] b);
        for (int k = 7; k >= 0; k--) begin
            @(negedge clk);
            slot_en = 1'b1;
            ser_in  = b[k];
        end
    endtask

    // One slot carrying n bytes of a pattern, then extra junk bits.
    task automatic send_slot(int set, int first, int n, int extra, bit ack_end);
        for (int j = 0; j < n; j++) send_byte(pat(set, first + j));
        for (int j = 0; j < extra; j++) begin
            @(negedge clk);
            slot_en = 1'b1;
            ser_in  = j[0];
        end
        @(negedge clk);
        slot_en = 1'b0;
        cmd_ack = ack_end;
        @(negedge clk);
        cmd_ack = 1'b0;
        @(negedge clk);
    endtask

    task automatic chk_pool(string req, int set);
        for (int i = 0; i < 32; i++) begin
            rd_idx = 5'(i);
            #1;
            chk(req, {24'd0, rd_data}, {24'd0, pat(set, i)});
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk + 1 - n_fail, n_chk + 1);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 rx_active", rx_active, 0);
        chk("R1 pool_full", pool_full, 0);
        chk("R1 overflow", overflow, 0);
        chk("R1 rd_data", rd_data, 0);

        // R2 inactive receiver ignores a full slot
        send_slot(9, 0, 32, 0, 1'b0);
        chk("R2 ignored while idle", pool_full, 0);
        pulse(cmd_start);
        chk("R2 rx_active", rx_active, 1);

        // R3 activation inside a running slot: slot is ignored
        pulse(cmd_reset);
        @(negedge clk) slot_en = 1'b1; ser_in = 1'b1;
        @(negedge clk) cmd_start = 1'b1;
        @(negedge clk) cmd_start = 1'b0;
        for (int j = 0; j < 12; j++) @(negedge clk) ser_in = j[1];
        @(negedge clk) slot_en = 1'b0;
        @(negedge clk);
        // R3/R4 31 bytes, then one byte plus 4 trailing bits
        send_slot(1, 0, 31, 0, 1'b0);
        chk("R5 not full at 31", pool_full, 0);
        send_slot(1, 31, 1, 4, 1'b0);
        chk("R5 pool_full at 32", pool_full, 1);
        chk_pool("R3 R4 R5 pool A", 1);

        // R6 second pool fills while A is held, then drop one byte
        send_slot(2, 0, 16, 0, 1'b0);
        send_slot(2, 16, 16, 0, 1'b0);
        chk("R6 no overflow yet", overflow, 0);
        chk_pool("R6 held pool unchanged", 1);
        send_slot(7, 0, 1, 0, 1'b0);
        chk("R6 overflow set", overflow, 1);
        chk_pool("R6 dropped byte not stored", 1);

        // R7 ack with complete filling pool: swap, stays full
        pulse(cmd_ack);
        chk("R7 stays full", pool_full, 1);
        chk("R6 overflow sticky", overflow, 1);
        chk_pool("R7 pool B", 2);

        // R9 ack coinciding with the 32nd byte
        send_slot(3, 0, 31, 0, 1'b0);
        send_slot(3, 31, 1, 0, 1'b1);
        chk("R9 pool_full", pool_full, 1);
        chk_pool("R9 pool C", 3);

        // R7 ack with empty filling pool clears; R8 second ack is a no-op
        pulse(cmd_ack);
        chk("R7 cleared", pool_full, 0);
        rd_idx = 5'd3; #1;
        chk("R7 rd_data zero", rd_data, 0);
        pulse(cmd_ack);
        chk("R8 pool_full", pool_full, 0);
        chk("R8 overflow", overflow, 1);
        send_slot(4, 0, 32, 0, 1'b0);
        chk("R8 fill intact", pool_full, 1);
        chk_pool("R8 pool F", 4);

        // R10 reset with start in same cycle, partial fill pending
        send_slot(5, 0, 5, 3, 1'b0);
        @(negedge clk) cmd_reset = 1'b1; cmd_start = 1'b1;
        @(negedge clk) cmd_reset = 1'b0; cmd_start = 1'b0;
        chk("R10 rx_active", rx_active, 0);
        chk("R10 pool_full", pool_full, 0);
        chk("R10 overflow", overflow, 0);
        pulse(cmd_start);
        send_slot(6, 0, 32, 0, 1'b0);
        chk("R10 full after restart", pool_full, 1);
        chk_pool("R10 pool emptied", 6);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule